// File: doc/BRIEF.md
# Write-Only I2C Display Command Slave

This block is a receive-only I2C slave that sits in front of a small graphic display controller. It samples the bus lines with the system clock, cleans them up, and recognises START and STOP conditions. It answers one 7-bit address. The upper six bits of that address are fixed at `011110`, and a strap input supplies the lowest bit, so two such slaves can share one bus.

Once it has been addressed for writing, the slave reads every transfer as a fixed frame. The first byte sets the display state: enable, dark/inverse, power-down, addressing direction and the 3-bit bank (Y) index. The second byte sets the 7-bit column (X) index. Every byte after that is display data. The slave acknowledges each accepted byte. It acts on a byte at the moment the acknowledge slot opens, either by updating the held control fields with a one-cycle strobe or by presenting the byte on a write port with a one-cycle strobe. It never transmits data and does not stretch the clock.

Top module: `i2c_disp_cmd_slave`

## Requirements
- R1: An address byte equal to `{6'b011110, addr_sel, 1'b0}` (7-bit address first, then R/W bit 0) is acknowledged, and either strap value selects its own address.
- R2: An address byte whose upper seven bits differ from the selected address, or whose R/W bit is 1 (read), gets no acknowledge. That byte and all bytes after it produce no acknowledge and no strobe until the next START.
- R3: START is a falling SDA while SCL is high. STOP is a rising SDA while SCL is high. A repeated START in the middle of a frame restarts parsing at the address byte.
- R4: The first byte after an acknowledged address loads the control fields with a one-cycle `ctrl_we` pulse: `ctrl_e` from bit 6, `ctrl_d` from bit 5, `ctrl_pd` from bit 4, `ctrl_v` from bit 3 and `ctrl_y` from bits 2:0. Bit 7 is ignored. The fields change at no other time.
- R5: The second byte loads `xaddr` from bits 6:0 with a one-cycle `xaddr_we` pulse. `xaddr` changes at no other time.
- R6: Each further byte, from zero up to any count, is acknowledged and produces one `wr_stb` pulse with the byte on `wr_byte`.
- R7: A strobe is issued in the cycle when the acknowledge slot opens, which is the filtered SCL fall after the eighth bit. At most one strobe is high in any cycle, and `sda_pull` is high alongside it.
- R8: An acknowledge holds `sda_pull` high from the SCL fall after the eighth bit until the SCL fall after the ninth bit, covering the whole high period of the ninth clock.
- R9: A pulse on SCL or SDA shorter than `FILT_LEN` clock cycles (16 cycles = 64 ns at 250 MHz) has no effect.
- R10: After reset `ctrl_pd` is 1, the other control fields and `xaddr` are 0, `sda_pull` is 0 and every strobe is low.
- R11: A STOP ends the frame at once and releases SDA. Clocked bytes that follow it without a new START get no acknowledge and no strobe.
- R12: An SDA change that reaches the block in the same cycle as an SCL fall is treated as data, not as START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (as seen on the wire) |
| addr_sel | input | 1 | Strap supplying the address LSB |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| ctrl_we | output | 1 | One-cycle strobe: control fields updated |
| ctrl_e | output | 1 | Display enable field |
| ctrl_d | output | 1 | Display dark/inverse field |
| ctrl_pd | output | 1 | Power-down field |
| ctrl_v | output | 1 | Vertical-increment field |
| ctrl_y | output | 3 | Bank (Y) index |
| xaddr_we | output | 1 | One-cycle strobe: column index updated |
| xaddr | output | 7 | Column (X) index |
| wr_stb | output | 1 | One-cycle strobe: display data byte valid |
| wr_byte | output | 8 | Display data byte |

## Verification
The filtered SCL fall and a filtered SDA change can land in the same clock cycle. Zero hold time on the bus permits exactly that, and here a START or STOP detector could easily misfire. The bench provokes it by sending whole frames in which the master changes SDA at the same instant it drops SCL, using alternating data patterns and a release after the eighth bit. Since both lines pass through filters of equal latency, the two edges arrive at the parser together. The bench judges the result by the acknowledges and by the exact sequence of strobes and values, compared against its model on every clock: a spurious START or STOP would show up as a missing acknowledge or a lost strobe.

// File: rtl/i2c_disp_cmd_slave.sv
module i2c_disp_cmd_slave #(
  parameter int          FILT_LEN = 16,
  parameter logic [5:0]  ADDR_HI  = 6'b011110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel,
  output logic       sda_pull,
  output logic       ctrl_we,
  output logic       ctrl_e,
  output logic       ctrl_d,
  output logic       ctrl_pd,
  output logic       ctrl_v,
  output logic [2:0] ctrl_y,
  output logic       xaddr_we,
  output logic [6:0] xaddr,
  output logic       wr_stb,
  output logic [7:0] wr_byte
);

  typedef enum logic [1:0] {P_IDLE, P_ADDR, P_CMD, P_XA} phase_t;

  logic [1:0]          scl_s, sda_s;
  logic [FILT_LEN-1:0] scl_h, sda_h;
  logic                scl_f, sda_f, scl_q, sda_q;
  logic                in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_h <= '1;
      sda_h <= '1;
      scl_f <= 1'b1;
      sda_f <= 1'b1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[FILT_LEN-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT_LEN-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1;
      else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1;
      else if (~|sda_h) sda_f <= 1'b0;
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_c  = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  phase_t     ph;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       in_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= P_IDLE;
      in_data  <= 1'b0;
      sh       <= '0;
      cnt      <= '0;
      in_ack   <= 1'b0;
      sda_pull <= 1'b0;
      ctrl_we  <= 1'b0;
      xaddr_we <= 1'b0;
      wr_stb   <= 1'b0;
      ctrl_e   <= 1'b0;
      ctrl_d   <= 1'b0;
      ctrl_pd  <= 1'b1;
      ctrl_v   <= 1'b0;
      ctrl_y   <= '0;
      xaddr    <= '0;
      wr_byte  <= '0;
    end else begin
      ctrl_we  <= 1'b0;
      xaddr_we <= 1'b0;
      wr_stb   <= 1'b0;
      if (start_c || stop_c) begin
        ph       <= start_c ? P_ADDR : P_IDLE;
        in_data  <= 1'b0;
        cnt      <= '0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (ph != P_IDLE || in_data) begin
        if (scl_rise && !in_ack && cnt < 4'd8) begin
          sh  <= {sh[6:0], sda_f};
          cnt <= cnt + 4'd1;
        end else if (scl_fall && in_ack) begin
          in_ack   <= 1'b0;
          sda_pull <= 1'b0;
          cnt      <= '0;
        end else if (scl_fall && cnt == 4'd8) begin
          if (in_data) begin
            in_ack   <= 1'b1;
            sda_pull <= 1'b1;
            wr_stb   <= 1'b1;
            wr_byte  <= sh;
          end else begin
            case (ph)
              P_ADDR: begin
                if (sh == {ADDR_HI, addr_sel, 1'b0}) begin
                  in_ack   <= 1'b1;
                  sda_pull <= 1'b1;
                  ph       <= P_CMD;
                end else begin
                  ph  <= P_IDLE;
                  cnt <= '0;
                end
              end
              P_CMD: begin
                in_ack   <= 1'b1;
                sda_pull <= 1'b1;
                ctrl_we  <= 1'b1;
                {ctrl_e, ctrl_d, ctrl_pd, ctrl_v, ctrl_y} <= sh[6:0];
                ph       <= P_XA;
              end
              P_XA: begin
                in_ack   <= 1'b1;
                sda_pull <= 1'b1;
                xaddr_we <= 1'b1;
                xaddr    <= sh[6:0];
                ph       <= P_IDLE;
                in_data  <= 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we, xaddr_we, wr_stb}));

  assert_strobe_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we || xaddr_we || wr_stb) |-> sda_pull);

  assert_ack_held_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull && scl_f) |=> (sda_pull || !scl_f));

  assert_stop_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!sda_pull && !ctrl_we && !xaddr_we && !wr_stb));

  assert_start_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !sda_pull);

  assert_ctrl_only_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ctrl_e, ctrl_d, ctrl_pd, ctrl_v, ctrl_y}) |-> ctrl_we);

  assert_xaddr_only_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(xaddr) |-> xaddr_we);

endmodule

// File: tb/i2c_disp_cmd_slave_tb.sv
`timescale 1ns/1ps
module i2c_disp_cmd_slave_tb_top;
  localparam int H = 60;
  localparam int Q = 30;

  typedef struct { int kind; int val; string req; } exp_t;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1, addr_sel = 0;
  logic sda_pull, ctrl_we, ctrl_e, ctrl_d, ctrl_pd, ctrl_v, xaddr_we, wr_stb;
  logic [2:0] ctrl_y;
  logic [6:0] xaddr;
  logic [7:0] wr_byte;
  wire sda_bus = sda_m & ~sda_pull;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  i2c_disp_cmd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .addr_sel(addr_sel),
    .sda_pull(sda_pull), .ctrl_we(ctrl_we), .ctrl_e(ctrl_e), .ctrl_d(ctrl_d),
    .ctrl_pd(ctrl_pd), .ctrl_v(ctrl_v), .ctrl_y(ctrl_y), .xaddr_we(xaddr_we),
    .xaddr(xaddr), .wr_stb(wr_stb), .wr_byte(wr_byte));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic expect_stb(input int k, input int v, input string r);
    exp_t e;
    e.kind = k; e.val = v; e.req = r;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int n;
      int k;
      int v;
      n = int'(ctrl_we) + int'(xaddr_we) + int'(wr_stb);
      if (n != 0) begin
        k = ctrl_we ? 0 : (xaddr_we ? 1 : 2);
        v = ctrl_we ? int'({ctrl_e, ctrl_d, ctrl_pd, ctrl_v, ctrl_y}) :
            (xaddr_we ? int'(xaddr) : int'(wr_byte));
        chk(n == 1, "R7 one strobe", n, 1);
        chk(sda_pull, "R7 strobe with ack", int'(sda_pull), 1);
        if (exp_q.size() == 0) chk(0, "R2/R11 unexpected strobe", k, -1);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(k == e.kind, e.req, k, e.kind);
          chk(v == e.val, e.req, v, e.val);
        end
      end
    end
  end

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    waitn(Q); sda_m = 1; waitn(Q); scl_m = 1; waitn(H); sda_m = 0; waitn(H); scl_m = 0;
  endtask

  task automatic i2c_stop();
    waitn(Q); sda_m = 0; waitn(Q); scl_m = 1; waitn(H); sda_m = 1; waitn(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit coinc, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      if (!coinc || i == 7) begin waitn(Q); sda_m = b[i]; waitn(Q); end
      else waitn(H);
      if (glitch && i == 3) begin scl_m = 1; waitn(10); scl_m = 0; waitn(Q); end
      scl_m = 1; waitn(H);
      scl_m = 0;
      if (coinc) sda_m = (i > 0) ? b[i-1] : 1'b1;
    end
    if (!coinc) begin waitn(Q); sda_m = 1; waitn(Q); end
    else waitn(H);
    scl_m = 1; waitn(Q);
    acked = !sda_bus;
    waitn(Q); scl_m = 0;
  endtask

  task automatic sb(input logic [7:0] b, input bit want, input string r);
    bit a;
    send_byte(b, 1'b0, 1'b0, a);
    chk(a == want, r, int'(a), int'(want));
  endtask

  task automatic frame_done(input string r);
    waitn(40);
    chk(exp_q.size() == 0, r, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    waitn(5); rst_n = 1; waitn(5);
    chk(ctrl_pd == 1, "R10 pd", int'(ctrl_pd), 1);
    chk({ctrl_e, ctrl_d, ctrl_v, ctrl_y} == 0, "R10 fields", int'({ctrl_e, ctrl_d, ctrl_v, ctrl_y}), 0);
    chk(xaddr == 0 && !sda_pull, "R10 xaddr/pull", int'({sda_pull, xaddr}), 0);

    // R1 R4 R5 R6: full frame, strap 0, command bit 7 set
    i2c_start();
    sb(8'h78, 1, "R1 addr ack");
    expect_stb(0, 'h5A, "R4 ctrl"); sb(8'hDA, 1, "R4 ack");
    expect_stb(1, 'h64, "R5 xaddr"); sb(8'h64, 1, "R5 ack");
    expect_stb(2, 'hA5, "R6 data"); sb(8'hA5, 1, "R6 ack");
    expect_stb(2, 'h3C, "R6 data"); sb(8'h3C, 1, "R6 ack");
    expect_stb(2, 'hFF, "R6 data"); sb(8'hFF, 1, "R6 ack");
    i2c_stop(); frame_done("R6 all strobes");
    chk({ctrl_e, ctrl_d, ctrl_pd, ctrl_v, ctrl_y} == 7'h5A, "R4 held fields",
        int'({ctrl_e, ctrl_d, ctrl_pd, ctrl_v, ctrl_y}), 'h5A);

    // R2: other strap address and read bit are refused
    i2c_start(); sb(8'h7A, 0, "R2 wrong addr"); sb(8'h11, 0, "R2 ignored"); sb(8'h22, 0, "R2 ignored");
    i2c_stop(); frame_done("R2 no strobe");
    i2c_start(); sb(8'h79, 0, "R2 read bit"); sb(8'h11, 0, "R2 ignored"); i2c_stop();
    chk(xaddr == 7'h64, "R2 xaddr kept", int'(xaddr), 'h64);

    // R1 strap 1, zero data bytes
    addr_sel = 1;
    i2c_start(); sb(8'h7A, 1, "R1 strap1 ack");
    expect_stb(0, 'h00, "R4 ctrl zero"); sb(8'h00, 1, "R4 ack");
    expect_stb(1, 'h05, "R5 xaddr"); sb(8'h05, 1, "R5 ack");
    i2c_stop(); frame_done("R6 zero data");
    chk(ctrl_pd == 0, "R4 pd cleared", int'(ctrl_pd), 0);
    i2c_start(); sb(8'h78, 0, "R1 strap1 rejects 0x3C"); i2c_stop();

    // R3: repeated start mid-frame
    i2c_start(); sb(8'h7A, 1, "R3 addr");
    expect_stb(0, 'h11, "R3 ctrl1"); sb(8'h11, 1, "R3 ack");
    i2c_start(); sb(8'h7A, 1, "R3 readdressed");
    expect_stb(0, 'h22, "R3 ctrl2"); sb(8'h22, 1, "R3 ack");
    expect_stb(1, 'h10, "R3 xaddr"); sb(8'h10, 1, "R3 ack");
    expect_stb(2, 'h77, "R3 data"); sb(8'h77, 1, "R3 ack");
    i2c_stop(); frame_done("R3 strobes");

    // R11: stop mid-frame, then bytes without start
    i2c_start(); sb(8'h7A, 1, "R11 addr");
    expect_stb(0, 'h30, "R11 ctrl"); sb(8'h30, 1, "R11 ack");
    i2c_stop();
    waitn(Q); scl_m = 0; waitn(Q);
    sb(8'h7A, 0, "R11 no start"); sb(8'h44, 0, "R11 no start");
    i2c_stop(); frame_done("R11 no strobe");
    chk(xaddr == 7'h10, "R11 xaddr kept", int'(xaddr), 'h10);

    // R12: SDA changes at the same instant SCL falls
    i2c_start();
    send_byte(8'h7A, 1'b1, 1'b0, a); chk(a, "R12 addr ack", int'(a), 1);
    expect_stb(0, 'h4B, "R12 ctrl"); send_byte(8'h4B, 1'b1, 1'b0, a); chk(a, "R12 ack", int'(a), 1);
    expect_stb(1, 'h2A, "R12 xaddr"); send_byte(8'h2A, 1'b1, 1'b0, a); chk(a, "R12 ack", int'(a), 1);
    expect_stb(2, 'h55, "R12 data"); send_byte(8'h55, 1'b1, 1'b0, a); chk(a, "R12 ack", int'(a), 1);
    expect_stb(2, 'hAA, "R12 data"); send_byte(8'hAA, 1'b1, 1'b0, a); chk(a, "R12 ack", int'(a), 1);
    expect_stb(2, 'h00, "R12 data"); send_byte(8'h00, 1'b1, 1'b0, a); chk(a, "R12 ack", int'(a), 1);
    i2c_stop(); frame_done("R12 strobes");

    // R9: short SDA pulse while idle is no START; short SCL pulse is no bit
    waitn(Q); sda_m = 0; waitn(10); sda_m = 1; waitn(Q);
    scl_m = 0; waitn(Q);
    sb(8'h7A, 0, "R9 sda glitch no start");
    i2c_stop(); frame_done("R9 no strobe");
    i2c_start(); sb(8'h7A, 1, "R9 addr");
    expect_stb(0, 'h61, "R9 ctrl"); sb(8'h61, 1, "R9 ack");
    expect_stb(1, 'h33, "R9 xaddr"); sb(8'h33, 1, "R9 ack");
    expect_stb(2, 'h96, "R9 data intact");
    send_byte(8'h96, 1'b0, 1'b1, a); chk(a, "R9 scl glitch ack", int'(a), 1);
    i2c_stop(); frame_done("R9 strobes");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule